// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This unit lets one core of a small cluster raise an interrupt on another core. Each core receives one interrupt line from the unit. The unit keeps a pending bit for every pair of target and sender. A receiving core can therefore find out which cores have signalled it and acknowledge each of them separately. When several cores signal the same target, their requests merge into a single asserted line, and the target sees several bits in its source mask.

Software reaches the unit through one shared command port. Each command carries the issuing core number, an 8-bit opcode, a 16-bit parameter and a 32-bit data word. The data word is not used by any of the commands listed here. Query results appear in a readback register. The port follows valid/ready rules. A command is taken on every rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while reset is held, so back-pressure exists only during reset. A command offered while `cmd_ready` is low is not taken, and the master must hold it until `cmd_ready` is high. The `PRESENT` parameter marks which core slots are populated.

Top module: `ipi_hub`

## Requirements
- R1: A taken raise command (opcode 0x01) from issuer i whose parameter names a present target t, with t different from i, sets sender bit i in the mask of t. `irq[t]` is then high from the edge that takes the command.
- R2: A raise command whose target equals the issuing core changes no interrupt line and no source mask.
- R3: A status query (opcode 0x02) with a target in the parameter loads the readback with 1 when that target has any sender bit set. It loads 0 when the target has no sender bit set or the target is out of range or absent. The readback takes this value on the edge that takes the command.
- R4: A source query (opcode 0x03) loads the readback with the issuer's sender mask, zero-extended, where bit k means core k has signalled the issuer. A single sender therefore reads 1, 2, 4 or 8.
- R5: Raise commands from several senders to one target leave one asserted line, and the target's source query shows one bit for each sender.
- R6: An acknowledge command (opcode 0x04) clears only the sender bit named by its parameter in the issuer's own mask. The issuer's line stays high while other bits remain set, and it drops on the edge that clears the last bit.
- R7: A raise or acknowledge command is ignored in either of these cases: its parameter is at least NUM_CORES or names an absent core, or its issuer is absent.
- R8: A taken command with any other opcode leaves the lines, the masks and the readback unchanged. A cycle without a taken command does the same.
- R9: Reset clears every mask, drives all lines low, zeroes the readback and holds `cmd_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken; low only during reset |
| cmd_core | input | CID_W | Number of the issuing core |
| cmd_op | input | 8 | Opcode |
| cmd_param | input | PARAM_W | Target core or sender core number |
| cmd_data | input | DATA_W | Data word, not used by these opcodes |
| rb_data | output | DATA_W | Readback register |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
The port takes one command per cycle. The collisions that matter are between a new command and state left by earlier ones. Two of these are tested. In the first, a raise arrives for a target whose line is already held high by another sender. The test checks that the line shows no gap and that the source query then reads both bits. In the second, an acknowledge clears one sender while another sender is still pending. The test checks that the line stays high. It then checks that the line drops in the same cycle that the last bit is cleared.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_RAISE  = 8'h01,
    OP_STATUS = 8'h02,
    OP_SOURCE = 8'h03,
    OP_ACK    = 8'h04
  } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] PRESENT = '1,
  parameter int unsigned PARAM_W = 16,
  localparam int unsigned CID_W = $clog2(NUM_CORES)
) (
  input  logic               fire,
  input  logic [CID_W-1:0]   core,
  input  logic [OPC_W-1:0]   op,
  input  logic [PARAM_W-1:0] param,
  output logic               raise_v,
  output logic               ack_v,
  output logic               stat_v,
  output logic               src_v,
  output logic               param_ok,
  output logic [CID_W-1:0]   idx
);
  logic issuer_ok;
  logic take;

  always_comb begin
    idx       = param[CID_W-1:0];
    param_ok  = (param < PARAM_W'(NUM_CORES)) && PRESENT[idx];
    issuer_ok = (32'(core) < NUM_CORES) && PRESENT[core];
    take      = fire && issuer_ok;
    raise_v   = take && (op == OP_RAISE) && param_ok && (idx != core);
    ack_v     = take && (op == OP_ACK) && param_ok;
    stat_v    = take && (op == OP_STATUS);
    src_v     = take && (op == OP_SOURCE);
  end
endmodule

// File: rtl/ipi_src_bank.sv
module ipi_src_bank #(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CID_W = $clog2(NUM_CORES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                raise_v,
  input  logic                                ack_v,
  input  logic [CID_W-1:0]                    issuer,
  input  logic [CID_W-1:0]                    idx,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] src_q,
  output logic [NUM_CORES-1:0]                irq
);
  for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
      logic set_b, clr_b;
      assign set_b = raise_v && (32'(idx) == t) && (32'(issuer) == s);
      assign clr_b = ack_v && (32'(issuer) == t) && (32'(idx) == s);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     src_q[t][s] <= 1'b0;
        else if (set_b) src_q[t][s] <= 1'b1;
        else if (clr_b) src_q[t][s] <= 1'b0;
      end
    end
    assign irq[t] = |src_q[t];
  end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CID_W = $clog2(NUM_CORES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                stat_v,
  input  logic                                src_v,
  input  logic                                param_ok,
  input  logic [CID_W-1:0]                    issuer,
  input  logic [CID_W-1:0]                    idx,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] src_q,
  output logic [DATA_W-1:0]                   rb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rb_q <= '0;
    else if (stat_v) rb_q <= DATA_W'(param_ok && (|src_q[idx]));
    else if (src_v)  rb_q <= DATA_W'(src_q[issuer]);
  end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] PRESENT = 4'b0111,
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CID_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [CID_W-1:0]     cmd_core,
  input  logic [OPC_W-1:0]     cmd_op,
  input  logic [PARAM_W-1:0]   cmd_param,
  input  logic [DATA_W-1:0]    cmd_data,
  output logic [DATA_W-1:0]    rb_data,
  output logic [NUM_CORES-1:0] irq
);
  logic ready_q;
  logic raise_v, ack_v, stat_v, src_v, param_ok;
  logic [CID_W-1:0] idx;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] src_q;
  logic data_unused;

  assign data_unused = ^cmd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign cmd_ready = ready_q;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .PRESENT(PRESENT), .PARAM_W(PARAM_W)) u_dec (
    .fire(cmd_valid && ready_q), .core(cmd_core), .op(cmd_op), .param(cmd_param),
    .raise_v(raise_v), .ack_v(ack_v), .stat_v(stat_v), .src_v(src_v),
    .param_ok(param_ok), .idx(idx)
  );

  ipi_src_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk(clk), .rst_n(rst_n), .raise_v(raise_v), .ack_v(ack_v),
    .issuer(cmd_core), .idx(idx), .src_q(src_q), .irq(irq)
  );

  ipi_readback #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .stat_v(stat_v), .src_v(src_v), .param_ok(param_ok),
    .issuer(cmd_core), .idx(idx), .src_q(src_q), .rb_q(rb_data)
  );
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] PRESENT = 4'b0111,
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CID_W = $clog2(NUM_CORES)
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cmd_valid,
  input logic                                cmd_ready,
  input logic [CID_W-1:0]                    cmd_core,
  input logic [OPC_W-1:0]                    cmd_op,
  input logic [PARAM_W-1:0]                  cmd_param,
  input logic [DATA_W-1:0]                   rb_data,
  input logic [NUM_CORES-1:0]                irq,
  input logic [NUM_CORES-1:0][NUM_CORES-1:0] src_q
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    if (PRESENT[c]) begin : g_pres
      // R1
      a_r1_raise_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op == OP_RAISE && cmd_param == PARAM_W'(c)
          && PRESENT[cmd_core] && 32'(cmd_core) != c |=> irq[c]);
      // R3
      a_r3_status_reflects_line: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op == OP_STATUS && cmd_param == PARAM_W'(c) && PRESENT[cmd_core]
          |=> rb_data == DATA_W'($past(irq[c])));
    end
    // R2
    a_r2_self_raise_inert: assert property (@(posedge clk) disable iff (!rst_n)
      take && cmd_op == OP_RAISE && cmd_param == PARAM_W'(c) && 32'(cmd_core) == c
        |=> irq[c] == $past(irq[c]));
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
      // R6
      a_r6_ack_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op == OP_ACK && 32'(cmd_core) == c && cmd_param == PARAM_W'(s)
          |=> !src_q[c][s]);
    end
  end

  // R8
  a_r8_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(irq) && $stable(rb_data));
  // R9
  a_r9_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq == '0 && rb_data == '0);
endmodule

bind ipi_hub ipi_hub_chk #(
  .NUM_CORES(NUM_CORES), .PRESENT(PRESENT), .PARAM_W(PARAM_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_core(cmd_core), .cmd_op(cmd_op), .cmd_param(cmd_param),
  .rb_data(rb_data), .irq(irq), .src_q(src_q)
);

// File: tb/tb_ipi_hub.sv
module tb_ipi_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_core = '0;
  logic [7:0]  cmd_op = '0;
  logic [15:0] cmd_param = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] rb_data;
  logic [3:0]  irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_hub dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_core(cmd_core), .cmd_op(cmd_op), .cmd_param(cmd_param),
    .cmd_data(cmd_data), .rb_data(rb_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] core, input logic [7:0] op, input logic [15:0] p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_core = core; cmd_op = op; cmd_param = p;
    cmd_data = 32'hdead_0000 | 32'(p);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 ready low in reset", 32'(cmd_ready), 0);
    chk(irq == 4'b0, "R9 lines low in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready after reset", 32'(cmd_ready), 1);
    chk(rb_data == 0, "R9 readback cleared", rb_data, 0);
  endtask

  task automatic t_basic();
    issue(0, 8'h01, 1);
    chk(irq == 4'b0010, "R1 raise 0->1", 32'(irq), 32'h2);
    issue(1, 8'h03, 0);
    chk(rb_data == 1, "R4 source single sender", rb_data, 1);
    issue(1, 8'h04, 0);
    chk(irq == 4'b0, "R6 ack last drops line", 32'(irq), 0);
  endtask

  task automatic t_self();
    issue(2, 8'h01, 2);
    chk(irq == 4'b0, "R2 self raise inert", 32'(irq), 0);
    issue(2, 8'h03, 0);
    chk(rb_data == 0, "R2 self raise leaves mask empty", rb_data, 0);
  endtask

  task automatic t_merge();
    issue(0, 8'h01, 2);
    issue(1, 8'h01, 2);
    chk(irq == 4'b0100, "R5 merged single line", 32'(irq), 32'h4);
    issue(2, 8'h03, 0);
    chk(rb_data == 3, "R5 mask holds both senders", rb_data, 3);
    issue(0, 8'h02, 2);
    chk(rb_data == 1, "R3 status pending target", rb_data, 1);
    issue(0, 8'h02, 0);
    chk(rb_data == 0, "R3 status idle target", rb_data, 0);
    issue(2, 8'h04, 1);
    chk(irq == 4'b0100, "R6 line held by remaining sender", 32'(irq), 32'h4);
    issue(2, 8'h03, 0);
    chk(rb_data == 1, "R6 only named sender cleared", rb_data, 1);
    issue(2, 8'h04, 0);
    chk(irq == 4'b0, "R6 drop on last ack", 32'(irq), 0);
  endtask

  task automatic t_range();
    issue(0, 8'h01, 3);
    chk(irq == 4'b0, "R7 absent target ignored", 32'(irq), 0);
    issue(0, 8'h01, 9);
    chk(irq == 4'b0, "R7 out of range target ignored", 32'(irq), 0);
    issue(3, 8'h01, 0);
    chk(irq == 4'b0, "R7 absent issuer ignored", 32'(irq), 0);
    issue(0, 8'h01, 1);
    issue(1, 8'h04, 7);
    issue(1, 8'h04, 3);
    chk(irq == 4'b0010, "R7 bad ack ignored", 32'(irq), 32'h2);
    issue(1, 8'h03, 0);
    chk(rb_data == 1, "R7 mask intact", rb_data, 1);
    issue(0, 8'h02, 9);
    chk(rb_data == 0, "R3 out of range status reads 0", rb_data, 0);
  endtask

  task automatic t_other();
    issue(1, 8'h03, 0);
    issue(0, 8'h55, 1);
    chk(irq == 4'b0010 && rb_data == 1, "R8 unknown opcode inert", {rb_data[27:0], irq}, 32'h12);
    @(negedge clk);
    cmd_core = 0; cmd_op = 8'h01; cmd_param = 2;
    repeat (3) @(negedge clk);
    chk(irq == 4'b0010 && rb_data == 1, "R8 no valid no effect", {rb_data[27:0], irq}, 32'h12);
  endtask

  task automatic t_midreset();
    do_reset();
    chk(irq == 4'b0, "R9 pending cleared by reset", 32'(irq), 0);
    issue(1, 8'h03, 0);
    chk(rb_data == 0, "R9 mask cleared by reset", rb_data, 0);
  endtask

  initial begin
    do_reset();
    t_basic();
    t_self();
    t_merge();
    t_range();
    t_other();
    t_midreset();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule